// File: doc/BRIEF.md
# UART Interrupt Gating and Modem Status Tracker

This block serves one UART channel. It collects the channel's interrupt sources, ranks them, reports the winner as a 4-bit identification code, and drives a single interrupt line. It also watches the four active-low modem handshake pins (clear-to-send, data-set-ready, ring, carrier detect), brings each one into the clock domain, and keeps a latched status word. That word holds the current pin levels and a sticky change flag for each pin.

Software writes two registers over a small write port. The first is a 4-bit source-enable register. The second is a control register whose bit 3 acts as a master gate on the interrupt line. Pulsing the status-read strobe tells the block that the status word has been read, and the change flags are cleared. Receiver line error, receive data available and transmit holding empty arrive as level signals from the neighbouring serial logic.

Top module: `uart_irq_gate`

## Requirements
- R1: After a synchronous reset: `irq_o` is 0, `iid_o` is 4'b0001, the enable register and the gate bit are 0, `msr_o[3:0]` is 0, and `msr_o[7:4]` is 0 while all pins are high.
- R2: `irq_o` is 1 only when all three hold: control bit 3 is 1 (`cfg_sel`=1, `cfg_wdata[3]`), at least one source is pending, and that source is enabled. Enable bits are written with `cfg_sel`=0: bit0 receive data, bit1 transmit empty, bit2 line error, bit3 modem status. `irq_o` follows one clock after its inputs.
- R3: An enabled, present receiver line error gives `iid_o`=4'b0110, whatever else is pending.
- R4: Without a line error, enabled receive data gives 4'b0100. Below it, enabled transmit empty gives 4'b0010.
- R5: Enabled modem status (any change flag set) has the lowest rank and gives 4'b0000. With nothing enabled and pending, `iid_o` is 4'b0001.
- R6: A change in either direction on `cts_n`, `dsr_n` or `cd_n` sets `msr_o[0]`, `msr_o[1]` or `msr_o[3]` respectively.
- R7: `msr_o[2]` is set only when `ri_n` goes from 0 to 1. A 1-to-0 change leaves it clear.
- R8: `msr_o[4]`, `[5]`, `[6]` and `[7]` show the inverted synchronised levels of `cts_n`, `dsr_n`, `ri_n` and `cd_n`.
- R9: A one-cycle pulse on `msr_rd` clears `msr_o[3:0]` on the next clock. If a new change arrives in the same cycle as the clear, the new change wins.
- R10: Each pin passes through `SYNC_STAGES` flops. A pin change shows in the level bits after `SYNC_STAGES` clocks, and in the change flag one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects the enable register, 1 selects the control register |
| cfg_wdata | input | 8 | Write data |
| msr_rd | input | 1 | Status-word read strobe; clears the change flags |
| rx_err | input | 1 | Receiver line error present |
| rx_avail | input | 1 | Receive data available |
| tx_empty | input | 1 | Transmit holding register empty |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring indicator pin, active low |
| cd_n | input | 1 | Carrier detect pin, active low |
| irq_o | output | 1 | Gated interrupt line |
| iid_o | output | 4 | Highest-rank pending source code |
| msr_o | output | 8 | Modem status word: change flags [3:0], levels [7:4] |

## Verification
The bench builds the block with the default `SYNC_STAGES` of 2 and derives every latency from that parameter. This makes the exact-cycle check of R10 meaningful: the level bit must appear after two clocks and the change flag after three. The short chain also lets the priority walk clear the sources one by one in a few cycles each. With it, the bench can also line up a status read with a fresh pin edge, which exercises the clear-versus-set case.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NPIN  = 4;
  localparam int NSRC  = 4;
  localparam int IID_W = 4;

  // pin indices within the synchronised vector
  localparam int PIN_CTS = 0;
  localparam int PIN_DSR = 1;
  localparam int PIN_RI  = 2;
  localparam int PIN_CD  = 3;

  // enable register bit positions
  localparam int EN_RXD = 0;
  localparam int EN_TXE = 1;
  localparam int EN_ERR = 2;
  localparam int EN_MOD = 3;

  typedef logic [IID_W-1:0] iid_t;
  localparam iid_t IID_NONE = 4'b0001;
  localparam iid_t IID_ERR  = 4'b0110;
  localparam iid_t IID_RXD  = 4'b0100;
  localparam iid_t IID_TXE  = 4'b0010;
  localparam iid_t IID_MOD  = 4'b0000;

  localparam int GATE_BIT = 3;
endpackage

// File: rtl/uart_pin_sync.sv
module uart_pin_sync #(
  parameter int STAGES = 2,
  parameter int W      = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '1;
      else     sh <= {sh[STAGES-2:0], pin_i[g]};
    end
    assign pin_o[g] = sh[STAGES-1];
  end
endmodule

// File: rtl/uart_modem_delta.sv
module uart_modem_delta
  import uart_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] lvl_n,
  input  logic            rd_clr,
  output logic [NPIN-1:0] delta_o,
  output logic [NPIN-1:0] chg_o,
  output logic            ri_rise_o
);
  logic [NPIN-1:0] prev_q;
  logic [NPIN-1:0] delta_q;

  for (genvar g = 0; g < NPIN; g++) begin : g_chg
    if (g == PIN_RI) begin : g_trail
      assign chg_o[g] = lvl_n[g] & ~prev_q[g];
    end else begin : g_any
      assign chg_o[g] = lvl_n[g] ^ prev_q[g];
    end
  end
  assign ri_rise_o = chg_o[PIN_RI];

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= '1;
      delta_q <= '0;
    end else begin
      prev_q  <= lvl_n;
      delta_q <= (rd_clr ? '0 : delta_q) | chg_o;
    end
  end
  assign delta_o = delta_q;
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] en_i,
  input  logic            gate_i,
  output logic            any_pend_o,
  output iid_t            iid_o,
  output logic            irq_o
);
  logic [NSRC-1:0] pend;
  iid_t            iid_d;

  assign pend       = src_i & en_i;
  assign any_pend_o = |pend;

  always_comb begin
    if      (pend[EN_ERR]) iid_d = IID_ERR;
    else if (pend[EN_RXD]) iid_d = IID_RXD;
    else if (pend[EN_TXE]) iid_d = IID_TXE;
    else if (pend[EN_MOD]) iid_d = IID_MOD;
    else                   iid_d = IID_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iid_o <= IID_NONE;
      irq_o <= 1'b0;
    end else begin
      iid_o <= iid_d;
      irq_o <= gate_i & any_pend_o;
    end
  end
endmodule

// File: rtl/uart_irq_gate.sv
module uart_irq_gate
  import uart_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              msr_rd,
  input  logic              rx_err,
  input  logic              rx_avail,
  input  logic              tx_empty,
  input  logic              cts_n,
  input  logic              dsr_n,
  input  logic              ri_n,
  input  logic              cd_n,
  output logic              irq_o,
  output logic [IID_W-1:0]  iid_o,
  output logic [2*NPIN-1:0] msr_o
);
  logic [NSRC-1:0] ier_q;
  logic            gate_q;
  logic [NPIN-1:0] sync_n;
  logic [NPIN-1:0] delta_q;
  logic [NPIN-1:0] chg;
  logic            ri_rise;
  logic            any_pend;
  logic [NSRC-1:0] src;
  logic [NPIN-1:0] pins_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      ier_q  <= '0;
      gate_q <= 1'b0;
    end else if (cfg_wr) begin
      if (cfg_sel) gate_q <= cfg_wdata[GATE_BIT];
      else         ier_q  <= cfg_wdata[NSRC-1:0];
    end
  end

  assign pins_n[PIN_CTS] = cts_n;
  assign pins_n[PIN_DSR] = dsr_n;
  assign pins_n[PIN_RI]  = ri_n;
  assign pins_n[PIN_CD]  = cd_n;

  uart_pin_sync #(.STAGES(SYNC_STAGES), .W(NPIN)) u_sync (
    .clk(clk), .rst(rst), .pin_i(pins_n), .pin_o(sync_n)
  );

  uart_modem_delta u_delta (
    .clk(clk), .rst(rst), .lvl_n(sync_n), .rd_clr(msr_rd),
    .delta_o(delta_q), .chg_o(chg), .ri_rise_o(ri_rise)
  );

  assign src[EN_RXD] = rx_avail;
  assign src[EN_TXE] = tx_empty;
  assign src[EN_ERR] = rx_err;
  assign src[EN_MOD] = |delta_q;

  uart_irq_prio u_prio (
    .clk(clk), .rst(rst), .src_i(src), .en_i(ier_q), .gate_i(gate_q),
    .any_pend_o(any_pend), .iid_o(iid_o), .irq_o(irq_o)
  );

  assign msr_o = {~sync_n, delta_q};
endmodule

// File: rtl/uart_irq_gate_chk.sv
module uart_irq_gate_chk (
  input logic       clk,
  input logic       rst,
  input logic       msr_rd,
  input logic       rx_err,
  input logic [3:0] ier_q,
  input logic       gate_q,
  input logic [3:0] chg,
  input logic       ri_rise,
  input logic       irq_o,
  input logic [3:0] iid_o,
  input logic [7:0] msr_o
);
  p_irq_needs_gate_r2: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(gate_q));

  p_idle_no_irq_r5: assert property (@(posedge clk) disable iff (rst)
    (iid_o == 4'b0001) |-> !irq_o);

  p_err_wins_r3: assert property (@(posedge clk) disable iff (rst)
    $past(rx_err && ier_q[2]) |-> (iid_o == 4'b0110));

  p_rd_clears_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(msr_rd) && ($past(chg) == 4'b0000)) |-> (msr_o[3:0] == 4'b0000));

  p_ri_trailing_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(msr_o[2]) |-> $past(ri_rise));
endmodule

bind uart_irq_gate uart_irq_gate_chk chk_i (
  .clk(clk), .rst(rst), .msr_rd(msr_rd), .rx_err(rx_err), .ier_q(ier_q),
  .gate_q(gate_q), .chg(chg), .ri_rise(ri_rise), .irq_o(irq_o),
  .iid_o(iid_o), .msr_o(msr_o)
);

// File: tb/uart_irq_gate_tb_top.sv
`timescale 1ns/1ps
module uart_irq_gate_tb_top;
  localparam int SYNC = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0, cfg_sel = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       msr_rd = 1'b0;
  logic       rx_err = 1'b0, rx_avail = 1'b0, tx_empty = 1'b0;
  logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, cd_n = 1'b1;
  logic       irq_o;
  logic [3:0] iid_o;
  logic [7:0] msr_o;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_irq_gate #(.SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .msr_rd(msr_rd), .rx_err(rx_err),
    .rx_avail(rx_avail), .tx_empty(tx_empty), .cts_n(cts_n),
    .dsr_n(dsr_n), .ri_n(ri_n), .cd_n(cd_n), .irq_o(irq_o),
    .iid_o(iid_o), .msr_o(msr_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic rd_msr;
    @(negedge clk); msr_rd = 1'b1;
    @(negedge clk); msr_rd = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1; cyc(3); rst = 1'b0; cyc(1);
    chk("R1 irq", {7'd0, irq_o}, 8'd0);
    chk("R1 iid", {4'd0, iid_o}, 8'h01);
    chk("R1 msr", msr_o, 8'h00);
  endtask

  task automatic t_gate;
    wr(1'b0, 8'h01); rx_avail = 1'b1; cyc(2);
    chk("R2 gate off irq", {7'd0, irq_o}, 8'd0);
    chk("R4 rx data iid", {4'd0, iid_o}, 8'h04);
    wr(1'b1, 8'h08); cyc(2);
    chk("R2 gate on irq", {7'd0, irq_o}, 8'd1);
    wr(1'b0, 8'h00); cyc(2);
    chk("R2 disabled irq", {7'd0, irq_o}, 8'd0);
    chk("R5 none iid", {4'd0, iid_o}, 8'h01);
    rx_avail = 1'b0;
  endtask

  task automatic t_sync_latency;
    @(negedge clk); cd_n = 1'b0;
    repeat (SYNC) @(posedge clk);
    @(negedge clk);
    chk("R10 level after sync", {7'd0, msr_o[7]}, 8'd1);
    chk("R10 flag not yet", {7'd0, msr_o[3]}, 8'd0);
    @(negedge clk);
    chk("R10 flag one later", {7'd0, msr_o[3]}, 8'd1);
    rd_msr(); cyc(1);
    chk("R9 cleared", {4'd0, msr_o[3:0]}, 8'h00);
    cd_n = 1'b1; cyc(SYNC + 2);
    chk("R6 cd rise flag", {4'd0, msr_o[3:0]}, 8'h08);
    rd_msr();
  endtask

  task automatic t_deltas;
    cts_n = 1'b0; dsr_n = 1'b0; cyc(SYNC + 2);
    chk("R6 cts/dsr fall", {4'd0, msr_o[3:0]}, 8'h03);
    chk("R8 levels", {4'd0, msr_o[7:4]}, 8'h03);
    rd_msr(); cyc(1);
    chk("R9 clear", {4'd0, msr_o[3:0]}, 8'h00);
    cts_n = 1'b1; cyc(SYNC + 2);
    chk("R6 cts rise", {4'd0, msr_o[3:0]}, 8'h01);
    rd_msr(); dsr_n = 1'b1; cyc(SYNC + 2); rd_msr();
  endtask

  task automatic t_ring;
    ri_n = 1'b0; cyc(SYNC + 2);
    chk("R7 ri fall no flag", {4'd0, msr_o[3:0]}, 8'h00);
    chk("R8 ri level", {7'd0, msr_o[6]}, 8'd1);
    ri_n = 1'b1; cyc(SYNC + 2);
    chk("R7 ri rise flag", {4'd0, msr_o[3:0]}, 8'h04);
    rd_msr(); cyc(1);
  endtask

  task automatic t_clear_race;
    // pin change lands in delta register in same edge as read clear
    @(negedge clk); dsr_n = 1'b0;
    repeat (SYNC) @(posedge clk);
    @(negedge clk); msr_rd = 1'b1;
    @(negedge clk); msr_rd = 1'b0;
    chk("R9 set wins", {4'd0, msr_o[3:0]}, 8'h02);
    rd_msr(); dsr_n = 1'b1; cyc(SYNC + 2); rd_msr();
  endtask

  task automatic t_priority;
    wr(1'b0, 8'h0F); wr(1'b1, 8'h08);
    cts_n = 1'b0; cyc(SYNC + 2);
    rx_err = 1'b1; rx_avail = 1'b1; tx_empty = 1'b1; cyc(2);
    chk("R3 err top", {4'd0, iid_o}, 8'h06);
    chk("R2 irq on", {7'd0, irq_o}, 8'd1);
    rx_err = 1'b0; cyc(2);
    chk("R4 rx data next", {4'd0, iid_o}, 8'h04);
    rx_avail = 1'b0; cyc(2);
    chk("R4 tx empty next", {4'd0, iid_o}, 8'h02);
    tx_empty = 1'b0; cyc(2);
    chk("R5 modem last", {4'd0, iid_o}, 8'h00);
    chk("R5 modem irq", {7'd0, irq_o}, 8'd1);
    rd_msr(); cyc(2);
    chk("R5 none", {4'd0, iid_o}, 8'h01);
    chk("R5 irq off", {7'd0, irq_o}, 8'd0);
  endtask

  initial begin
    t_reset();
    t_gate();
    t_sync_latency();
    t_deltas();
    t_ring();
    t_clear_race();
    t_priority();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule